// File: doc/BRIEF.md
# Dual-Processor Watchdog Supervisor with Fail-Over Decision

This block watches over a pair of redundant processors that share one control job. Each processor has its own service timer. The processor must service the timer with a kick pulse often enough. When the timer runs out, the block sends that processor a fixed-width reset pulse and increments a count of back-to-back timeouts. A kick that arrives while the processor is running clears that count. If the processor is still silent after the allowed number of consecutive resets, further resets are judged useless. The block then drops that processor's active-low soft-error flag and stops resetting it.

Each processor also reports hardware trouble on a separate fault line. The block brings that line into its clock domain through two flip-flops and detects its rising edge. A decision stage registers a new soft error or a new hardware fault on a processor. It then pulls low the active-low takeover line of the other processor, which tells the healthy processor to carry the full workload. From that moment the faulty processor is isolated: it gets no further reset pulses and its kicks are ignored. The takeover command and the isolation stay in force until the global reset.

All pins are plain control and status levels or single-cycle pulses. No data moves through the block, so it has no valid/ready stream interface and needs no back-pressure rules.

Top module: `dual_cpu_supervisor`

## Requirements
- R1: With no kick, a processor's timer expires TIMEOUT_CYC cycles after its last kick, or after reset is released. On that edge its reset pulse starts. A kick sampled on any edge before that restarts the full interval.
- R2: A reset pulse stays high for exactly RST_PULSE_CYC cycles. Kicks during the pulse are ignored. The timer restarts its full interval when the pulse ends.
- R3: Each timeout that issues a reset adds one to a count of consecutive resets. A kick sampled while the timer is running sets the count back to zero.
- R4: A timeout that happens after RST_LIMIT consecutive resets issues no pulse. Instead it drives that processor's soft_ok_o bit from 1 to 0 on the same edge, and the bit stays 0 until rst_n is asserted.
- R5: A rising edge on hard_fault_i[i] passes through two synchronizer flip-flops and an edge detector. If the input goes high just after clock edge e, processor i becomes faulty on edge e+3.
- R6: When soft_ok_o[i] falls, takeover_n_o of the partner (index i XOR 1) goes to 0 one cycle later.
- R7: takeover_n_o bits idle at 1. Once a bit drops to 0 it stays 0 until rst_n is asserted.
- R8: Once a processor is faulty, its timer stops. It receives no new reset pulse, and its kicks have no effect.
- R9: While rst_n is low, cpu_rst_o is 00, soft_ok_o is 11 and takeover_n_o is 11.
- R10: The two processors are supervised independently. A timeout, soft error or hardware fault on one never changes the other's reset pulse or soft_ok_o bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global active-low reset, asynchronous assert |
| kick_i | input | 2 | Per-processor timer service pulse, sampled on clk |
| hard_fault_i | input | 2 | Per-processor hardware fault level, asynchronous, active high |
| cpu_rst_o | output | 2 | Per-processor reset pulse, active high |
| soft_ok_o | output | 2 | Per-processor soft-error flag, 1 while healthy, 0 after the reset limit |
| takeover_n_o | output | 2 | Active-low command for processor i to take over its partner's work |

## Verification
On every cycle the assertions check these properties: the exact reset pulse width, that a pulse starts only after an edge with no kick, that the soft-error flag and the takeover lines are sticky, that the partner's takeover follows a soft error by one cycle, and that a faulty processor gets no new reset pulse. The bench scenarios show the things a per-cycle property cannot show. They check the exact cycles at which timeouts and escalation happen. They show that a kick clears the consecutive count but a kick inside a pulse does not. They check the three-edge latency of the hardware-fault path, and that one processor's trouble leaves the other's outputs unchanged.

// File: rtl/sup_pkg.sv
package sup_pkg;

  localparam int NUM_CPU = 2;

  typedef enum logic [1:0] {
    WD_RUN   = 2'd0,
    WD_PULSE = 2'd1,
    WD_HALT  = 2'd2,
    WD_DEAD  = 2'd3
  } wd_state_e;

endpackage

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 1000,
  parameter int RST_PULSE_CYC = 16,
  parameter int RST_LIMIT     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic halt_i,
  output logic cpu_rst_o,
  output logic soft_err_o
);

  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int PLS_W = $clog2(RST_PULSE_CYC + 1);
  localparam int STK_W = $clog2(RST_LIMIT + 2);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [PLS_W-1:0] PLS_FULL = PLS_W'(RST_PULSE_CYC);
  localparam logic [PLS_W-1:0] PLS_ONE  = PLS_W'(1);
  localparam logic [STK_W-1:0] STK_MAX  = STK_W'(RST_LIMIT);

  wd_state_e        state_q;
  logic [CNT_W-1:0] tmr_q;
  logic [PLS_W-1:0] pls_q;
  logic [STK_W-1:0] streak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WD_RUN;
      tmr_q    <= '0;
      pls_q    <= '0;
      streak_q <= '0;
    end else begin
      unique case (state_q)
        WD_RUN: begin
          if (halt_i) begin
            state_q <= WD_HALT;
          end else if (kick_i) begin
            tmr_q    <= '0;
            streak_q <= '0;
          end else if (tmr_q == CNT_LAST) begin
            tmr_q <= '0;
            if (streak_q == STK_MAX) begin
              state_q <= WD_DEAD;
            end else begin
              state_q  <= WD_PULSE;
              pls_q    <= PLS_FULL;
              streak_q <= streak_q + STK_W'(1);
            end
          end else begin
            tmr_q <= tmr_q + CNT_W'(1);
          end
        end
        WD_PULSE: begin
          if (pls_q == PLS_ONE) begin
            pls_q   <= '0;
            tmr_q   <= '0;
            state_q <= halt_i ? WD_HALT : WD_RUN;
          end else begin
            pls_q <= pls_q - PLS_W'(1);
          end
        end
        WD_HALT: state_q <= WD_HALT;
        WD_DEAD: state_q <= WD_DEAD;
      endcase
    end
  end

  assign cpu_rst_o  = (state_q == WD_PULSE);
  assign soft_err_o = (state_q == WD_DEAD);

endmodule

// File: rtl/sup_sync_edge.sv
module sup_sync_edge #(
  parameter int WIDTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] chain_q [SYNC_STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= SYNC_STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s <= SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/sup_decision.sv
module sup_decision (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_err_i,
  input  logic hard_rise_i,
  output logic faulty_o
);

  logic soft_prev_q;
  logic faulty_q;
  logic fault_evt;

  assign fault_evt = (soft_err_i & ~soft_prev_q) | hard_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_prev_q <= 1'b0;
      faulty_q    <= 1'b0;
    end else begin
      soft_prev_q <= soft_err_i;
      if (fault_evt) faulty_q <= 1'b1;
    end
  end

  assign faulty_o = faulty_q;

endmodule

// File: rtl/dual_cpu_supervisor.sv
module dual_cpu_supervisor
  import sup_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 1000,
  parameter int RST_PULSE_CYC = 16,
  parameter int RST_LIMIT     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CPU-1:0]   kick_i,
  input  logic [NUM_CPU-1:0]   hard_fault_i,
  output logic [NUM_CPU-1:0]   cpu_rst_o,
  output logic [NUM_CPU-1:0]   soft_ok_o,
  output logic [NUM_CPU-1:0]   takeover_n_o
);

  logic [NUM_CPU-1:0] hard_rise;
  logic [NUM_CPU-1:0] soft_err;
  logic [NUM_CPU-1:0] faulty;

  sup_sync_edge #(
    .WIDTH       (NUM_CPU),
    .SYNC_STAGES (2)
  ) u_hard_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hard_fault_i),
    .rise_o  (hard_rise)
  );

  for (genvar ch = 0; ch < NUM_CPU; ch++) begin : g_cpu
    localparam int PARTNER = ch ^ 1;

    sup_watchdog #(
      .TIMEOUT_CYC   (TIMEOUT_CYC),
      .RST_PULSE_CYC (RST_PULSE_CYC),
      .RST_LIMIT     (RST_LIMIT)
    ) u_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .kick_i     (kick_i[ch]),
      .halt_i     (faulty[ch]),
      .cpu_rst_o  (cpu_rst_o[ch]),
      .soft_err_o (soft_err[ch])
    );

    sup_decision u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_err_i  (soft_err[ch]),
      .hard_rise_i (hard_rise[ch]),
      .faulty_o    (faulty[ch])
    );

    assign soft_ok_o[ch]    = ~soft_err[ch];
    assign takeover_n_o[ch] = ~faulty[PARTNER];
  end

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int TIMEOUT_CYC   = 1000,
  parameter int RST_PULSE_CYC = 16,
  parameter int RST_LIMIT     = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] kick_i,
  input logic [1:0] cpu_rst_o,
  input logic [1:0] soft_ok_o,
  input logic [1:0] takeover_n_o
);

  localparam int HW = $clog2(RST_PULSE_CYC + 2);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    localparam int PTN = i ^ 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= '0;
      else if (cpu_rst_o[i]) hi_cnt <= hi_cnt + HW'(1);
      else hi_cnt <= '0;
    end

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o[i] |-> (hi_cnt < HW'(RST_PULSE_CYC))); // R2
    AST_PULSE_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst_o[i]) |-> (hi_cnt == HW'(RST_PULSE_CYC))); // R2
    AST_PULSE_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_o[i]) |-> !$past(kick_i[i])); // R1
    AST_DEAD_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_ok_o[i] |-> !cpu_rst_o[i]); // R4
    AST_SOFT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_ok_o[i] |=> !soft_ok_o[i]); // R4
    AST_TAKEOVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !takeover_n_o[i] |=> !takeover_n_o[i]); // R7
    AST_SOFT_TO_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(soft_ok_o[i]) |=> !takeover_n_o[PTN]); // R6
    AST_ISOLATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!takeover_n_o[PTN] && !cpu_rst_o[i]) |=> !cpu_rst_o[i]); // R8
  end

endmodule

bind dual_cpu_supervisor sup_checker #(
  .TIMEOUT_CYC   (TIMEOUT_CYC),
  .RST_PULSE_CYC (RST_PULSE_CYC),
  .RST_LIMIT     (RST_LIMIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .kick_i       (kick_i),
  .cpu_rst_o    (cpu_rst_o),
  .soft_ok_o    (soft_ok_o),
  .takeover_n_o (takeover_n_o)
);

// File: tb/dual_cpu_supervisor_tb.sv
module dual_cpu_supervisor_tb;

  localparam int T_CYC = 20;
  localparam int P_CYC = 4;
  localparam int LIM   = 2;

  // event kinds
  localparam int EV_RST_RISE = 0;
  localparam int EV_RST_FALL = 1;
  localparam int EV_SOFT_LOW = 2;
  localparam int EV_TK_LOW   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] kick = 2'b00;
  logic [1:0] hard = 2'b00;
  logic [1:0] cpu_rst, soft_ok, tk_n;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int kick_per [2] = '{0, 0};
  int kick_stop[2] = '{0, 0};
  int kick_xtra[2] = '{-1, -1};

  int    exp_q[$];
  string req_q[$];

  logic [1:0] prev_rst, prev_ok, prev_tk;

  always #10 clk = ~clk;

  dual_cpu_supervisor #(
    .TIMEOUT_CYC   (T_CYC),
    .RST_PULSE_CYC (P_CYC),
    .RST_LIMIT     (LIM)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .kick_i       (kick),
    .hard_fault_i (hard),
    .cpu_rst_o    (cpu_rst),
    .soft_ok_o    (soft_ok),
    .takeover_n_o (tk_n)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // kick generator: kick lands on edge cyc+1
  always @(negedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      logic k;
      k = 1'b0;
      if (rst_n && kick_per[ch] != 0 && ((cyc + 1) % kick_per[ch]) == 0 &&
          (cyc + 1) <= kick_stop[ch]) k = 1'b1;
      if (rst_n && (cyc + 1) == kick_xtra[ch]) k = 1'b1;
      kick[ch] = k;
    end
  end

  function automatic int enc(int kind, int ch, int c);
    return kind * 100000 + ch * 10000 + c;
  endfunction

  task automatic expect_ev(int kind, int ch, int c, string req);
    exp_q.push_back(enc(kind, ch, c));
    req_q.push_back(req);
  endtask

  task automatic seen(int kind, int ch);
    int    got;
    int    want;
    string req;
    got = enc(kind, ch, cyc);
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL unexpected event actual=%0d expected=none (R10)", got);
    end else begin
      want = exp_q.pop_front();
      req  = req_q.pop_front();
      if (got != want) begin
        failures++;
        $display("FAIL %s event actual=%0d expected=%0d", req, got, want);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (cpu_rst[ch] && !prev_rst[ch]) seen(EV_RST_RISE, ch);
        if (!cpu_rst[ch] && prev_rst[ch]) seen(EV_RST_FALL, ch);
        if (!soft_ok[ch] && prev_ok[ch]) seen(EV_SOFT_LOW, ch);
        if (!tk_n[ch] && prev_tk[ch]) seen(EV_TK_LOW, ch);
      end
    end
    prev_rst = cpu_rst;
    prev_ok  = soft_ok;
    prev_tk  = tk_n;
  end

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic start_test;
    rst_n = 1'b0;
    hard  = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9 cpu_rst in reset", int'(cpu_rst), 0);
    chk("R9 soft_ok in reset", int'(soft_ok), 3);
    chk("R9 takeover_n in reset", int'(tk_n), 3);
    rst_n = 1'b1;
  endtask

  task automatic finish_test(int end_cyc, string req);
    while (cyc < end_cyc) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing events actual=%0d expected=0", req, exp_q.size());
      exp_q.delete();
      req_q.delete();
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Test 1: escalation to soft error and partner takeover (R1 R2 R3 R4 R6 R7 R10)
    kick_per  = '{10, 10};
    kick_stop = '{30, 1000000};
    kick_xtra = '{-1, -1};
    expect_ev(EV_RST_RISE, 0, 50, "R1");
    expect_ev(EV_RST_FALL, 0, 54, "R2");
    expect_ev(EV_RST_RISE, 0, 74, "R2");
    expect_ev(EV_RST_FALL, 0, 78, "R2");
    expect_ev(EV_SOFT_LOW, 0, 98, "R4");
    expect_ev(EV_TK_LOW,   1, 99, "R6");
    start_test();
    finish_test(160, "R4");
    chk("R7 takeover held", int'(tk_n), 1);
    chk("R4 soft_ok held", int'(soft_ok), 2);
    chk("R10 other cpu rst", int'(cpu_rst), 0);

    // Test 2: kick after a reset clears the streak (R3)
    kick_xtra = '{60, -1};
    expect_ev(EV_RST_RISE, 0, 50,  "R3");
    expect_ev(EV_RST_FALL, 0, 54,  "R3");
    expect_ev(EV_RST_RISE, 0, 80,  "R3");
    expect_ev(EV_RST_FALL, 0, 84,  "R3");
    expect_ev(EV_RST_RISE, 0, 104, "R3");
    expect_ev(EV_RST_FALL, 0, 108, "R3");
    expect_ev(EV_SOFT_LOW, 0, 128, "R3");
    expect_ev(EV_TK_LOW,   1, 129, "R6");
    start_test();
    finish_test(180, "R3");

    // Test 3: kick inside a pulse is ignored (R2)
    kick_xtra = '{52, -1};
    expect_ev(EV_RST_RISE, 0, 50, "R2");
    expect_ev(EV_RST_FALL, 0, 54, "R2");
    expect_ev(EV_RST_RISE, 0, 74, "R2");
    expect_ev(EV_RST_FALL, 0, 78, "R2");
    expect_ev(EV_SOFT_LOW, 0, 98, "R2");
    expect_ev(EV_TK_LOW,   1, 99, "R6");
    start_test();
    finish_test(160, "R2");

    // Test 4: hardware fault latency and isolation (R5 R8)
    kick_xtra = '{-1, -1};
    expect_ev(EV_TK_LOW, 1, 43, "R5");
    start_test();
    wait_cyc(40);
    hard[0] = 1'b1;
    finish_test(150, "R8");
    chk("R8 no reset on isolated cpu", int'(cpu_rst), 0);
    chk("R5 soft_ok unaffected", int'(soft_ok), 3);
    chk("R7 takeover after hard fault", int'(tk_n), 1);

    // Test 5: both processors fail independently (R5 R10 R6)
    kick_per  = '{0, 10};
    kick_stop = '{0, 1000000};
    expect_ev(EV_RST_RISE, 0, 20, "R1");
    expect_ev(EV_TK_LOW,   0, 23, "R5");
    expect_ev(EV_RST_FALL, 0, 24, "R10");
    expect_ev(EV_RST_RISE, 0, 44, "R10");
    expect_ev(EV_RST_FALL, 0, 48, "R10");
    expect_ev(EV_SOFT_LOW, 0, 68, "R4");
    expect_ev(EV_TK_LOW,   1, 69, "R6");
    start_test();
    wait_cyc(20);
    hard[1] = 1'b1;
    wait_cyc(22);
    hard[1] = 1'b0;
    finish_test(130, "R10");
    chk("R7 both takeover low", int'(tk_n), 0);
    chk("R10 soft_ok per cpu", int'(soft_ok), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule